// File: doc/BRIEF.md
# Watchdog Timer with Register Lock

A 32-bit watchdog peripheral on a simple word-addressed register bus (address, write strobe, write data, combinational read data). Software programs a reload value. A down-counter then steps once per enabled tick. When the count is exhausted, the counter reloads and a timeout interrupt is raised. If software has not acknowledged that interrupt by the time the counter runs out again, and the reset output is enabled, the block asserts a sticky reset request. That request stays high until the system reset.

The tick rate comes from an external clock-enable input. Software can enable the interrupt and the reset output separately, read the live count, and read the interrupt state both before and after masking. A lock register guards the other registers against stray writes: a key value opens the lock and any other value closes it.

Top module: `wdog_timer`

## Requirements
- R1: After reset every register reads 0, irq is 0 and wdog_rst is 0. The block starts unlocked.
- R2: A write to offset 0x000 stores the reload value. From the next cycle the count at offset 0x004 equals that value.
- R3: Offset 0x004 is read-only and returns the live count. Writes to it change nothing.
- R4: The count drops by one on each cycle where tick_en=1 and control bit 0 (interrupt enable) is 1. Otherwise it holds.
- R5: A counting cycle that finds the count at 0 reloads the count from the reload value. The same cycle sets raw status bit 0 at offset 0x010.
- R6: Masked status bit 0 at offset 0x014 is raw status AND interrupt enable. The irq output always equals it.
- R7: Any write to offset 0x00C clears the raw status and reloads the count from the reload value.
- R8: If a counting cycle finds the count at 0 while raw status is already 1 and control bit 1 (reset enable) is 1, wdog_rst rises on the next edge. It then stays 1 until rst_n is asserted.
- R9: Control at offset 0x008 holds interrupt enable in bit 0 and reset enable in bit 1. Changing bit 0 from 0 to 1 reloads the count.
- R10: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and any other value locks it. Offset 0xC00 reads 1 when locked and 0 when unlocked. While locked, writes to all other offsets are ignored.
- R11: Unused register bits, and offsets that map to no register, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable that sets the tick rate |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Timeout interrupt (masked status) |
| wdog_rst | output | 1 | Sticky reset request |

## Verification
The live count can be read back, so a wrong counter state shows on a read of offset 0x004 on the next cycle. A wrong raw-status flop shows on offsets 0x010 and 0x014 and on irq in the same cycle. A corrupted lock flop shows up as a reload value that failed to change, or that changed when it should not have. A wrong status bit delays or advances wdog_rst by one full reload period. The directed sequences therefore check the exact tick on which the reset request rises.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int OFF_LOAD  = 'h000;
  localparam int OFF_COUNT = 'h004;
  localparam int OFF_CTRL  = 'h008;
  localparam int OFF_CLEAR = 'h00C;
  localparam int OFF_RAW   = 'h010;
  localparam int OFF_MASK  = 'h014;
  localparam int OFF_LOCK  = 'hC00;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] load_q,
  output logic          int_en_q,
  output logic          res_en_q,
  output logic          locked_q,
  output logic          ld_wr,
  output logic          clr_wr,
  output logic          en_rise
);
  logic          wr_ok, ctrl_wr, lock_wr;
  logic [DW-1:0] load_d;
  logic          int_en_d, res_en_d, locked_d;

  always_comb begin
    wr_ok   = bus_we && !locked_q;
    ld_wr   = wr_ok && (bus_addr == AW'(OFF_LOAD));
    ctrl_wr = wr_ok && (bus_addr == AW'(OFF_CTRL));
    clr_wr  = wr_ok && (bus_addr == AW'(OFF_CLEAR));
    lock_wr = bus_we && (bus_addr == AW'(OFF_LOCK));
    en_rise = ctrl_wr && bus_wdata[0] && !int_en_q;

    load_d   = load_q;
    int_en_d = int_en_q;
    res_en_d = res_en_q;
    locked_d = locked_q;
    if (ld_wr) load_d = bus_wdata;
    if (ctrl_wr) begin
      int_en_d = bus_wdata[0];
      res_en_d = bus_wdata[1];
    end
    if (lock_wr) locked_d = (bus_wdata[31:0] != UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= '0;
      int_en_q <= 1'b0;
      res_en_q <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      load_q   <= load_d;
      int_en_q <= int_en_d;
      res_en_q <= res_en_d;
      locked_q <= locked_d;
    end
  end

  // R10: while locked, a write to the reload register leaves it unchanged
  p_locked_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && bus_we && bus_addr == AW'(OFF_LOAD)) |=> $stable(load_q));

  // R10: the key value always opens the lock
  p_unlock_key_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFF_LOCK) && bus_wdata[31:0] == UNLOCK_KEY) |=> !locked_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          int_en,
  input  logic          res_en,
  input  logic [DW-1:0] load_q,
  input  logic          ld_wr,
  input  logic [DW-1:0] ld_val,
  input  logic          clr_wr,
  input  logic          en_rise,
  output logic [DW-1:0] cnt_q,
  output logic          raw_q,
  output logic          rst_q
);
  logic [DW-1:0] cnt_d;
  logic          raw_d, rst_d, step, expire;

  always_comb begin
    step   = tick_en && int_en && !ld_wr && !clr_wr && !en_rise;
    expire = step && (cnt_q == '0);
    cnt_d  = cnt_q;
    raw_d  = raw_q;
    rst_d  = rst_q;
    if (ld_wr)                 cnt_d = ld_val;
    else if (clr_wr || en_rise) cnt_d = load_q;
    else if (expire)            cnt_d = load_q;
    else if (step)              cnt_d = cnt_q - 1'b1;
    if (clr_wr)      raw_d = 1'b0;
    else if (expire) raw_d = 1'b1;
    if (expire && raw_q && res_en) rst_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      raw_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      raw_q <= raw_d;
      rst_q <= rst_d;
    end
  end

  p_load_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> cnt_q == $past(ld_val));

  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == '0) |=> (raw_q && cnt_q == $past(load_q)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !raw_q);

  p_rst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          wdog_rst
);
  logic [DW-1:0] load_q, cnt_q;
  logic          int_en, res_en, locked, ld_wr, clr_wr, en_rise, raw;
  logic          masked;

  wdog_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .load_q(load_q), .int_en_q(int_en),
    .res_en_q(res_en), .locked_q(locked), .ld_wr(ld_wr), .clr_wr(clr_wr),
    .en_rise(en_rise)
  );

  wdog_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .int_en(int_en),
    .res_en(res_en), .load_q(load_q), .ld_wr(ld_wr), .ld_val(bus_wdata),
    .clr_wr(clr_wr), .en_rise(en_rise), .cnt_q(cnt_q), .raw_q(raw),
    .rst_q(wdog_rst)
  );

  always_comb begin
    masked    = raw && int_en;
    irq       = masked;
    bus_rdata = '0;
    if      (bus_addr == AW'(OFF_LOAD))  bus_rdata = load_q;
    else if (bus_addr == AW'(OFF_COUNT)) bus_rdata = cnt_q;
    else if (bus_addr == AW'(OFF_CTRL))  bus_rdata = DW'({res_en, int_en});
    else if (bus_addr == AW'(OFF_RAW))   bus_rdata = DW'(raw);
    else if (bus_addr == AW'(OFF_MASK))  bus_rdata = DW'(masked);
    else if (bus_addr == AW'(OFF_LOCK))  bus_rdata = DW'(locked);
  end

  // R8: the reset request is only ever set while a timeout is pending
  p_rst_needs_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_rst) |-> $past(raw));
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic        clk, rst_n, tick_en, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, wdog_rst;
  int          errors, checks;

  // fields: [76] write, [75:64] offset, [63:32] write data, [31:0] expected read
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 12'h000, 32'h0, 32'h0},           // R1
    {1'b0, 12'h004, 32'h0, 32'h0},           // R1
    {1'b0, 12'h008, 32'h0, 32'h0},           // R1
    {1'b0, 12'hC00, 32'h0, 32'h0},           // R1
    {1'b1, 12'h000, 32'h100, 32'h0},
    {1'b0, 12'h000, 32'h0, 32'h100},         // R2
    {1'b0, 12'h004, 32'h0, 32'h100},         // R2
    {1'b1, 12'h004, 32'h55, 32'h0},
    {1'b0, 12'h004, 32'h0, 32'h100},         // R3
    {1'b1, 12'h008, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h008, 32'h0, 32'h3},           // R9 R11
    {1'b1, 12'h008, 32'h0, 32'h0},
    {1'b1, 12'hC00, 32'h1234, 32'h0},
    {1'b0, 12'hC00, 32'h0, 32'h1},           // R10
    {1'b1, 12'h000, 32'h7, 32'h0},
    {1'b0, 12'h000, 32'h0, 32'h100},         // R10
    {1'b1, 12'hC00, 32'h1ACC_E551, 32'h0},
    {1'b0, 12'hC00, 32'h0, 32'h0},           // R10
    {1'b0, 12'h020, 32'h0, 32'h0},           // R11
    {1'b0, 12'h010, 32'h0, 32'h0}            // R1
  };
  localparam int VREQ [NV] = '{1,1,1,1,0,2,2,0,3,0,11,0,0,10,0,10,0,10,11,1};

  wdog_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wdog_rst(wdog_rst)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors = 0; checks = 0;
    rst_n = 1'b0; tick_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rst", {31'b0, wdog_rst}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else rd(VEC[i][75:64], VEC[i][31:0], $sformatf("R%0d vec%0d", VREQ[i], i));
    end

    // R4: counting and holding
    wr(12'h000, 32'd10);
    wr(12'h008, 32'h1);
    rd(12'h004, 32'd10, "R9 reload on enable");
    ticks(3);
    rd(12'h004, 32'd7, "R4 decrement");
    wr(12'h008, 32'h0);
    ticks(2);
    rd(12'h004, 32'd7, "R4 hold when disabled");

    // R5 / R6: expiry and masking
    wr(12'h000, 32'd2);
    wr(12'h008, 32'h1);
    ticks(3);
    rd(12'h010, 32'h1, "R5 raw set");
    rd(12'h004, 32'd2, "R5 reload");
    rd(12'h014, 32'h1, "R6 masked");
    check("R6 irq", {31'b0, irq}, 32'h1);
    wr(12'h008, 32'h2);
    rd(12'h014, 32'h0, "R6 masked off");
    check("R6 irq off", {31'b0, irq}, 32'h0);
    rd(12'h010, 32'h1, "R6 raw unmasked");

    // R7: clear
    wr(12'h008, 32'h1);
    ticks(1);
    wr(12'h00C, 32'h0);
    rd(12'h010, 32'h0, "R7 raw cleared");
    rd(12'h004, 32'd2, "R7 reload");

    // R8: two expiries without reset enable, then with it
    ticks(6);
    check("R8 no rst when disabled", {31'b0, wdog_rst}, 32'h0);
    wr(12'h008, 32'h3);
    ticks(2);
    check("R8 not yet", {31'b0, wdog_rst}, 32'h0);
    ticks(1);
    check("R8 rst asserted", {31'b0, wdog_rst}, 32'h1);
    wr(12'h008, 32'h0);
    wr(12'h00C, 32'h0);
    check("R8 rst sticky", {31'b0, wdog_rst}, 32'h1);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 rst released", {31'b0, wdog_rst}, 32'h0);
    rd(12'h000, 32'h0, "R1 load after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule